// File: doc/BRIEF.md
# Panel Power-Management Timer Controller

This block decides when a flat-panel display drops into its low-power states. It runs three timers. Two of them count whole minutes: a standby timer, and a backlight timer that switches the backlight off when it expires. Either timer can be restarted by host register traffic or by an external activity input, and each of those four paths has its own enable bit. The third timer counts seconds. It debounces a suspend request input, so suspend mode is entered only after the request has been held long enough.

Both time bases come from one input tick through two prescaler stages, and both stages are set by parameters. A bench can shrink a minute to a few clock cycles. Software can force standby or suspend on at any time. It can also take direct control of the panel power and backlight enables, using one override bit and one value bit for each. Clock gating and the actual shutdown of the display are handled elsewhere.

Top module: `panel_pm_ctrl`

## Requirements
- R1: With the standby minute field at 0, the standby timer is off, and standbyMode is high only while the force-standby bit is set.
- R2: With the standby minute field at N (1 to 15), standbyMode goes high on the N-th minute tick after the last restart. Minute ticks are free-running and occur once every TICKS_PER_SEC*SECS_PER_MIN input ticks.
- R3: A host access while control bit 0 is set, or an external activity pulse while control bit 1 is set, restarts the standby count and clears timed standby by the next cycle. Activity on a disabled path, or any activity while suspendMode is high, is ignored.
- R4: The backlight minute field has the same meaning for the backlight timer. When that timer expires, backlightEn is cleared. A value of 0 disables the timer.
- R5: The backlight timer is restarted by a host access while control bit 2 is set, or by an external activity pulse while control bit 3 is set. Disabled paths are ignored.
- R6: suspendReq is sampled through one register. suspendMode is entered once the sampled request has stayed high through N second ticks, where N is the 4-bit seconds field. If the request drops, the second count returns to zero and suspend is left. With N equal to 0, suspend follows the sampled request directly.
- R7: The force-standby bit sets standbyMode and the force-suspend bit sets suspendMode, whatever the timers are doing.
- R8: Without overrides, panelPowerEn equals NOT suspendMode, and backlightEn is high only when suspend, standby and the backlight timeout are all inactive.
- R9: When its override-enable bit is set, panelPowerEn (or backlightEn) takes the value of the matching override-value bit.
- R10: Writes use cfgAddr as follows. Address 0 holds the standby minutes in [3:0] and the backlight minutes in [7:4]. Address 1 holds the restart enables in [3:0]. Address 2 holds the suspend seconds in [3:0]. Address 3 holds force-standby [0], force-suspend [1], power override enable [2], power override value [3], backlight override enable [4] and backlight override value [5]. All fields reset to 0. Out of reset, standbyMode and suspendMode are 0 and panelPowerEn and backlightEn are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Time-base tick feeding the prescalers |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select |
| cfgWrData | input | 8 | Register write data |
| hostAccess | input | 1 | One-cycle pulse for each host access |
| extActivity | input | 1 | One-cycle pulse for external activity |
| suspendReq | input | 1 | Suspend request level |
| standbyMode | output | 1 | Standby state |
| suspendMode | output | 1 | Suspend state |
| panelPowerEn | output | 1 | Panel power enable |
| backlightEn | output | 1 | Backlight enable |

## Verification
A table of control-register values covers every combination of the force and override bits that matters. It shows whether each output follows its override, the suspend and standby states, or the default. The timers are exercised with activity on enabled paths, on disabled paths and during suspend, which separates a genuine restart from a restart that should have been ignored. A suspend request held steadily is compared with one broken by a short gap. This shows whether the second count clears or keeps adding up, and a zero seconds field confirms that suspend then follows the request directly.

// File: rtl/panel_pm_pkg.sv
package panel_pm_pkg;

  localparam logic [1:0] ADDR_TIMERS  = 2'd0;
  localparam logic [1:0] ADDR_RESTART = 2'd1;
  localparam logic [1:0] ADDR_DEBNC   = 2'd2;
  localparam logic [1:0] ADDR_FORCE   = 2'd3;

  typedef struct packed {
    logic [3:0] standbyMin;
    logic [3:0] backlightMin;
    logic       hostStby;
    logic       extStby;
    logic       hostBl;
    logic       extBl;
    logic [3:0] suspSec;
    logic       forceStandby;
    logic       forceSuspend;
    logic       pwrOvrEn;
    logic       pwrOvrVal;
    logic       blOvrEn;
    logic       blOvrVal;
  } pmCfg_t;

  typedef struct packed {
    logic restartStandby;
    logic restartBacklight;
    logic clearSuspend;
  } pmStrobe_t;

endpackage

// File: rtl/pm_sat_counter.sv
module pm_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         reached
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      count <= '0;
    end else if (step && (count < limit)) begin
      count <= count + W'(1);
    end
  end

  assign reached = (count >= limit);

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import panel_pm_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SECS_PER_MIN  = 60,
  parameter int TIMER_W       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseTick,
  input  pmStrobe_t          strobe,
  input  logic [TIMER_W-1:0] standbyLimit,
  input  logic [TIMER_W-1:0] backlightLimit,
  input  logic [TIMER_W-1:0] suspendLimit,
  output logic               standbyExpired,
  output logic               backlightExpired,
  output logic               suspendQualified
);

  localparam int SEC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int MIN_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(TICKS_PER_SEC - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SECS_PER_MIN - 1);

  logic [SEC_W-1:0] secPre;
  logic [MIN_W-1:0] minPre;
  logic             secTick;
  logic             minTick;
  logic             stbyHit;
  logic             blHit;

  assign secTick = baseTick && (secPre == SEC_LAST);
  assign minTick = secTick && (minPre == MIN_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secPre <= '0;
      minPre <= '0;
    end else begin
      if (baseTick) begin
        secPre <= secTick ? '0 : secPre + SEC_W'(1);
      end
      if (secTick) begin
        minPre <= minTick ? '0 : minPre + MIN_W'(1);
      end
    end
  end

  pm_sat_counter #(.W(TIMER_W)) stbyTimer (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.restartStandby),
    .step    (minTick),
    .limit   (standbyLimit),
    .reached (stbyHit)
  );

  pm_sat_counter #(.W(TIMER_W)) blTimer (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.restartBacklight),
    .step    (minTick),
    .limit   (backlightLimit),
    .reached (blHit)
  );

  pm_sat_counter #(.W(TIMER_W)) suspTimer (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.clearSuspend),
    .step    (secTick),
    .limit   (suspendLimit),
    .reached (suspendQualified)
  );

  assign standbyExpired   = stbyHit && (standbyLimit != '0);
  assign backlightExpired = blHit && (backlightLimit != '0);

endmodule

// File: rtl/pm_control.sv
module pm_control
  import panel_pm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgAddr,
  input  logic [7:0] cfgWrData,
  input  logic       hostAccess,
  input  logic       extActivity,
  input  logic       suspendReq,
  input  logic       standbyExpired,
  input  logic       backlightExpired,
  input  logic       suspendQualified,
  output pmCfg_t     cfg,
  output pmStrobe_t  strobe,
  output logic       standbyMode,
  output logic       suspendMode,
  output logic       panelPowerEn,
  output logic       backlightEn
);

  logic reqSync;
  logic stbyActivity;
  logic blActivity;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= '0;
      reqSync <= 1'b0;
    end else begin
      reqSync <= suspendReq;
      if (cfgWrEn) begin
        unique case (cfgAddr)
          ADDR_TIMERS: begin
            cfg.standbyMin   <= cfgWrData[3:0];
            cfg.backlightMin <= cfgWrData[7:4];
          end
          ADDR_RESTART: begin
            cfg.hostStby <= cfgWrData[0];
            cfg.extStby  <= cfgWrData[1];
            cfg.hostBl   <= cfgWrData[2];
            cfg.extBl    <= cfgWrData[3];
          end
          ADDR_DEBNC: begin
            cfg.suspSec <= cfgWrData[3:0];
          end
          ADDR_FORCE: begin
            cfg.forceStandby <= cfgWrData[0];
            cfg.forceSuspend <= cfgWrData[1];
            cfg.pwrOvrEn     <= cfgWrData[2];
            cfg.pwrOvrVal    <= cfgWrData[3];
            cfg.blOvrEn      <= cfgWrData[4];
            cfg.blOvrVal     <= cfgWrData[5];
          end
          default: ;
        endcase
      end
    end
  end

  assign suspendMode = cfg.forceSuspend || (reqSync && suspendQualified);
  assign standbyMode = cfg.forceStandby || standbyExpired;

  assign stbyActivity = (hostAccess && cfg.hostStby) || (extActivity && cfg.extStby);
  assign blActivity   = (hostAccess && cfg.hostBl) || (extActivity && cfg.extBl);

  always_comb begin
    strobe                  = '0;
    strobe.restartStandby   = stbyActivity && !suspendMode;
    strobe.restartBacklight = blActivity;
    strobe.clearSuspend     = !reqSync;
  end

  assign panelPowerEn = cfg.pwrOvrEn ? cfg.pwrOvrVal : !suspendMode;
  assign backlightEn  = cfg.blOvrEn ? cfg.blOvrVal
                      : !(suspendMode || standbyMode || backlightExpired);

endmodule

// File: rtl/panel_pm_ctrl.sv
module panel_pm_ctrl
  import panel_pm_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgAddr,
  input  logic [7:0] cfgWrData,
  input  logic       hostAccess,
  input  logic       extActivity,
  input  logic       suspendReq,
  output logic       standbyMode,
  output logic       suspendMode,
  output logic       panelPowerEn,
  output logic       backlightEn
);

  pmCfg_t    cfg;
  pmStrobe_t strobe;
  logic      standbyExpired;
  logic      backlightExpired;
  logic      suspendQualified;

  pm_control ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .cfgWrEn          (cfgWrEn),
    .cfgAddr          (cfgAddr),
    .cfgWrData        (cfgWrData),
    .hostAccess       (hostAccess),
    .extActivity      (extActivity),
    .suspendReq       (suspendReq),
    .standbyExpired   (standbyExpired),
    .backlightExpired (backlightExpired),
    .suspendQualified (suspendQualified),
    .cfg              (cfg),
    .strobe           (strobe),
    .standbyMode      (standbyMode),
    .suspendMode      (suspendMode),
    .panelPowerEn     (panelPowerEn),
    .backlightEn      (backlightEn)
  );

  pm_datapath #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .SECS_PER_MIN  (SECS_PER_MIN),
    .TIMER_W       (4)
  ) dpath (
    .clk              (clk),
    .rstN             (rstN),
    .baseTick         (baseTick),
    .strobe           (strobe),
    .standbyLimit     (cfg.standbyMin),
    .backlightLimit   (cfg.backlightMin),
    .suspendLimit     (cfg.suspSec),
    .standbyExpired   (standbyExpired),
    .backlightExpired (backlightExpired),
    .suspendQualified (suspendQualified)
  );

endmodule

// File: rtl/panel_pm_checker.sv
module panel_pm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       suspendReq,
  input logic       standbyMode,
  input logic       suspendMode,
  input logic       panelPowerEn,
  input logic       backlightEn,
  input logic [3:0] standbyMin,
  input logic       forceStandby,
  input logic       forceSuspend,
  input logic       pwrOvrEn,
  input logic       pwrOvrVal,
  input logic       blOvrEn,
  input logic       blOvrVal
);

  AST_STBY_OFF_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (standbyMin == 4'd0 && !forceStandby) |-> !standbyMode); // R1

  AST_SUSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (suspendMode && !forceSuspend) |-> $past(suspendReq)); // R6

  AST_FORCE_STBY: assert property (@(posedge clk) disable iff (!rstN)
    forceStandby |-> standbyMode); // R7

  AST_FORCE_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    forceSuspend |-> suspendMode); // R7

  AST_PWR_OFF_IN_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    (suspendMode && !pwrOvrEn) |-> !panelPowerEn); // R8

  AST_BL_OFF_IN_LOWPWR: assert property (@(posedge clk) disable iff (!rstN)
    ((suspendMode || standbyMode) && !blOvrEn) |-> !backlightEn); // R8

  AST_PWR_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    pwrOvrEn |-> (panelPowerEn == pwrOvrVal)); // R9

  AST_BL_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    blOvrEn |-> (backlightEn == blOvrVal)); // R9

endmodule

bind panel_pm_ctrl panel_pm_checker chk (
  .clk          (clk),
  .rstN         (rstN),
  .suspendReq   (suspendReq),
  .standbyMode  (standbyMode),
  .suspendMode  (suspendMode),
  .panelPowerEn (panelPowerEn),
  .backlightEn  (backlightEn),
  .standbyMin   (cfg.standbyMin),
  .forceStandby (cfg.forceStandby),
  .forceSuspend (cfg.forceSuspend),
  .pwrOvrEn     (cfg.pwrOvrEn),
  .pwrOvrVal    (cfg.pwrOvrVal),
  .blOvrEn      (cfg.blOvrEn),
  .blOvrVal     (cfg.blOvrVal)
);

// File: tb/panel_pm_ctrl_test.sv
module panel_pm_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b1;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [7:0] cfgWrData = 8'd0;
  logic       hostAccess = 1'b0;
  logic       extActivity = 1'b0;
  logic       suspendReq = 1'b0;
  logic       standbyMode, suspendMode, panelPowerEn, backlightEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  panel_pm_ctrl #(.TICKS_PER_SEC(4), .SECS_PER_MIN(3)) uut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .hostAccess(hostAccess), .extActivity(extActivity), .suspendReq(suspendReq),
    .standbyMode(standbyMode), .suspendMode(suspendMode),
    .panelPowerEn(panelPowerEn), .backlightEn(backlightEn)
  );

  // force register value, expected {standby, suspend, power, backlight}: R7 R8 R9
  localparam logic [11:0] VEC [10] = '{
    {8'h00, 4'b0011}, {8'h01, 4'b1010}, {8'h02, 4'b0100}, {8'h03, 4'b1100},
    {8'h06, 4'b0100}, {8'h0E, 4'b0110}, {8'h32, 4'b0101}, {8'h10, 4'b0010},
    {8'h04, 4'b0001}, {8'h2C, 4'b0011}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseHost();
    @(negedge clk); hostAccess = 1'b1;
    @(negedge clk); hostAccess = 1'b0;
  endtask

  task automatic pulseExt();
    @(negedge clk); extActivity = 1'b1;
    @(negedge clk); extActivity = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    check("R10 reset outputs", {standbyMode, suspendMode, panelPowerEn, backlightEn}, 4'b0011);

    for (int i = 0; i < 10; i++) begin
      wr(2'd3, VEC[i][11:4]);
      check("R9 force/override table", {standbyMode, suspendMode, panelPowerEn, backlightEn}, VEC[i][3:0]);
    end
    wr(2'd3, 8'h00);

    // R1: standby timer disabled
    wr(2'd1, 8'h0F);
    waitCyc(60);
    check("R1 zero field keeps standby off", {3'b0, standbyMode}, 4'b0);

    // R2: timeout of 3 minutes (12 cycles each)
    wr(2'd0, 8'h03);
    pulseHost();
    waitCyc(22);
    check("R2 before timeout", {3'b0, standbyMode}, 4'b0);
    waitCyc(15);
    check("R2 after timeout", {3'b0, standbyMode}, 4'b1);
    check("R8 backlight off in standby", {3'b0, backlightEn}, 4'b0);

    // R3: restart paths
    pulseExt();
    check("R3 ext restart leaves standby", {3'b0, standbyMode}, 4'b0);
    wr(2'd1, 8'h05);
    waitCyc(40);
    check("R3 standby again", {3'b0, standbyMode}, 4'b1);
    pulseExt();
    check("R3 disabled ext path ignored", {3'b0, standbyMode}, 4'b1);
    pulseHost();
    check("R3 host restart", {3'b0, standbyMode}, 4'b0);
    waitCyc(40);
    wr(2'd3, 8'h02);
    pulseHost();
    check("R3 activity ignored in suspend", {3'b0, standbyMode}, 4'b1);
    wr(2'd3, 8'h00);
    pulseHost();
    check("R3 host restart after suspend", {3'b0, standbyMode}, 4'b0);

    // R4 R5: backlight timer of 2 minutes
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h04);
    pulseHost();
    waitCyc(10);
    check("R4 backlight before timeout", {3'b0, backlightEn}, 4'b1);
    waitCyc(16);
    check("R4 backlight after timeout", {3'b0, backlightEn}, 4'b0);
    check("R4 standby unaffected", {3'b0, standbyMode}, 4'b0);
    pulseExt();
    check("R5 disabled ext path ignored", {3'b0, backlightEn}, 4'b0);
    wr(2'd1, 8'h08);
    pulseExt();
    check("R5 ext restart backlight", {3'b0, backlightEn}, 4'b1);
    wr(2'd0, 8'h00);

    // R6: suspend debounce, 3 seconds (4 cycles each)
    wr(2'd2, 8'h03);
    @(negedge clk); suspendReq = 1'b1;
    waitCyc(7);
    check("R6 before debounce", {3'b0, suspendMode}, 4'b0);
    waitCyc(8);
    check("R6 after debounce", {3'b0, suspendMode}, 4'b1);
    check("R8 panel power off in suspend", {3'b0, panelPowerEn}, 4'b0);
    suspendReq = 1'b0;
    waitCyc(2);
    check("R6 release leaves suspend", {2'b0, suspendMode, panelPowerEn}, 4'b0001);
    suspendReq = 1'b1;
    waitCyc(6);
    suspendReq = 1'b0;
    waitCyc(3);
    suspendReq = 1'b1;
    waitCyc(6);
    check("R6 gap restarts count", {3'b0, suspendMode}, 4'b0);
    suspendReq = 1'b0;
    waitCyc(2);
    wr(2'd2, 8'h00);
    suspendReq = 1'b1;
    waitCyc(2);
    check("R6 zero field follows request", {3'b0, suspendMode}, 4'b1);
    suspendReq = 1'b0;
    waitCyc(2);
    check("R6 zero field release", {3'b0, suspendMode}, 4'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule